// File: doc/BRIEF.md
# Poison-Tagged Speculative Register File

This block is a small integer register file whose every entry carries a single poison bit next to its data. A set poison bit means the entry holds a deferred-fault token instead of a usable value. Operations arrive one per cycle. They are speculative load writebacks, speculative or ordinary ALU operations, a speculation check, and a poison test. The block writes data and poison together, spreads poison from sources to results, and traps when an ordinary operation touches a poisoned value.

A speculation check on a poisoned register does not trap. It emits a redirect carrying the recovery address supplied with the check. Whether a faulting speculative load is deferred is decided outside the block and arrives on the `defer_en` input. Every result (writeback, trap, redirect) is registered and appears on the outputs in the cycle after the operation is presented.

Top module: `ptrf_top`

## Requirements
- R1: After reset every register reads as data 0 with poison clear, and all outputs are low.
- R2: A speculative load (op code 1) without a fault writes `ld_data` to `dst` with poison clear. Results appear on the outputs one clock after the operation.
- R3: A speculative load with `ld_fault` high and `defer_en` high writes `ld_data` with poison set. With `defer_en` low it performs no write and raises `trap_valid` with `trap_kind` = 1.
- R4: A speculative ALU operation (op code 2) writes the ALU result, with poison equal to the OR of both source poison bits.
- R5: An ordinary ALU operation (op code 3) that reads a poisoned source raises `trap_valid` with `trap_kind` = 0. It leaves the destination unchanged.
- R6: An ordinary ALU operation on clean sources writes its result with poison clear, which also cleans a previously poisoned destination.
- R7: A check (op code 4) of a poisoned `src_a` raises `redir_valid` with `redir_target` = `chk_target`. A check of a clean register produces no output.
- R8: A poison test (op code 5) writes 1 or 0 to `dst` according to the poison bit of `src_a`, with poison clear, and never traps.
- R9: Register 0 reads as 0 with poison clear. Any write to it is dropped, and `wb_valid` stays low for it.
- R10: `alu_fn` selects 0 = add, 1 = subtract (a minus b), 2 = AND, 3 = XOR.
- R11: Op codes 0, 6 and 7, and any cycle with `op_valid` low, change no state and produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Operation kind |
| alu_fn | input | 2 | ALU function |
| src_a | input | AW | First source register |
| src_b | input | AW | Second source register |
| dst | input | AW | Destination register |
| ld_data | input | DW | Load return data |
| ld_fault | input | 1 | Load incurred a fault |
| defer_en | input | 1 | Fault-deferral policy |
| chk_target | input | TW | Recovery address of a check |
| wb_valid | output | 1 | A register was written |
| wb_idx | output | AW | Register written |
| wb_data | output | DW | Data written |
| wb_tag | output | 1 | Poison written |
| trap_valid | output | 1 | Fault raised |
| trap_kind | output | 1 | 0 consumption, 1 undeferred load fault |
| redir_valid | output | 1 | Redirect to recovery |
| redir_target | output | TW | Recovery address |

## Verification
On every cycle the assertions check several properties. Trap, writeback and redirect are mutually exclusive. Register 0 never shows a writeback. Redirects follow only checks. Poison tests never trap. Ordinary writes never carry poison. Only the scenarios can show that poison actually travels through a chain of dependent operations. They also show that a trapped write left the old value in place, that deferral follows the policy input, and that each ALU function computes the right value.

// File: rtl/ptrf_pkg.sv
package ptrf_pkg;
    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_SLOAD = 3'd1,
        OP_SALU  = 3'd2,
        OP_PALU  = 3'd3,
        OP_CHECK = 3'd4,
        OP_PTEST = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        FN_ADD = 2'd0,
        FN_SUB = 2'd1,
        FN_AND = 2'd2,
        FN_XOR = 2'd3
    } fn_e;

    localparam logic KIND_CONSUME = 1'b0;
    localparam logic KIND_NODEFER = 1'b1;
endpackage

// File: rtl/ptrf_storage.sv
module ptrf_storage #(
    parameter int NREG = 16,
    parameter int DW   = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic          wtag,
    input  logic [AW-1:0] ra,
    input  logic [AW-1:0] rb,
    output logic [DW-1:0] ra_data,
    output logic          ra_tag,
    output logic [DW-1:0] rb_data,
    output logic          rb_tag
);
    logic [DW-1:0] data_q [NREG];
    logic          tag_q  [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        if (g == 0) begin : g_zero
            assign data_q[g] = '0;
            assign tag_q[g]  = 1'b0;
        end else begin : g_live
            logic [DW-1:0] data_d;
            logic          tag_d;
            always_comb begin
                data_d = data_q[g];
                tag_d  = tag_q[g];
                if (we && widx == AW'(g)) begin
                    data_d = wdata;
                    tag_d  = wtag;
                end
            end
            always_ff @(posedge clk) begin
                if (rst) begin
                    data_q[g] <= '0;
                    tag_q[g]  <= 1'b0;
                end else begin
                    data_q[g] <= data_d;
                    tag_q[g]  <= tag_d;
                end
            end
        end
    end

    assign ra_data = data_q[ra];
    assign ra_tag  = tag_q[ra];
    assign rb_data = data_q[rb];
    assign rb_tag  = tag_q[rb];
endmodule

// File: rtl/ptrf_alu.sv
module ptrf_alu
    import ptrf_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [1:0]    fn,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);
    always_comb begin
        unique case (fn_e'(fn))
            FN_ADD:  y = a + b;
            FN_SUB:  y = a - b;
            FN_AND:  y = a & b;
            FN_XOR:  y = a ^ b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/ptrf_ctrl.sv
module ptrf_ctrl
    import ptrf_pkg::*;
#(
    parameter int DW  = 32,
    parameter int TW  = 32,
    parameter int AW  = 4
) (
    input  logic          op_valid,
    input  logic [2:0]    op_code,
    input  logic [AW-1:0] dst,
    input  logic          tag_a,
    input  logic          tag_b,
    input  logic [DW-1:0] alu_y,
    input  logic [DW-1:0] ld_data,
    input  logic          ld_fault,
    input  logic          defer_en,
    input  logic [TW-1:0] chk_target,
    output logic          we,
    output logic [DW-1:0] wdata,
    output logic          wtag,
    output logic          trap_v,
    output logic          trap_k,
    output logic          red_v,
    output logic [TW-1:0] red_t
);
    logic want_wr;

    always_comb begin
        want_wr = 1'b0;
        wdata   = '0;
        wtag    = 1'b0;
        trap_v  = 1'b0;
        trap_k  = KIND_CONSUME;
        red_v   = 1'b0;
        red_t   = '0;
        if (op_valid) begin
            case (op_e'(op_code))
                OP_SLOAD: begin
                    if (ld_fault && !defer_en) begin
                        trap_v = 1'b1;
                        trap_k = KIND_NODEFER;
                    end else begin
                        want_wr = 1'b1;
                        wdata   = ld_data;
                        wtag    = ld_fault;
                    end
                end
                OP_SALU: begin
                    want_wr = 1'b1;
                    wdata   = alu_y;
                    wtag    = tag_a | tag_b;
                end
                OP_PALU: begin
                    if (tag_a || tag_b) begin
                        trap_v = 1'b1;
                        trap_k = KIND_CONSUME;
                    end else begin
                        want_wr = 1'b1;
                        wdata   = alu_y;
                    end
                end
                OP_CHECK: begin
                    if (tag_a) begin
                        red_v = 1'b1;
                        red_t = chk_target;
                    end
                end
                OP_PTEST: begin
                    want_wr = 1'b1;
                    wdata   = DW'(tag_a);
                end
                default: ;
            endcase
        end
        we = want_wr && (dst != '0);
    end
endmodule

// File: rtl/ptrf_top.sv
module ptrf_top
    import ptrf_pkg::*;
#(
    parameter int NREG = 16,
    parameter int DW   = 32,
    parameter int TW   = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  logic [2:0]    op_code,
    input  logic [1:0]    alu_fn,
    input  logic [AW-1:0] src_a,
    input  logic [AW-1:0] src_b,
    input  logic [AW-1:0] dst,
    input  logic [DW-1:0] ld_data,
    input  logic          ld_fault,
    input  logic          defer_en,
    input  logic [TW-1:0] chk_target,
    output logic          wb_valid,
    output logic [AW-1:0] wb_idx,
    output logic [DW-1:0] wb_data,
    output logic          wb_tag,
    output logic          trap_valid,
    output logic          trap_kind,
    output logic          redir_valid,
    output logic [TW-1:0] redir_target
);
    typedef struct packed {
        logic          wb_v;
        logic [AW-1:0] wb_i;
        logic [DW-1:0] wb_d;
        logic          wb_t;
        logic          trap_v;
        logic          trap_k;
        logic          red_v;
        logic [TW-1:0] red_t;
    } out_s;

    out_s out_d, out_q;

    logic [DW-1:0] a_data, b_data, alu_y, wdata;
    logic          a_tag, b_tag, we, wtag, trap_v, trap_k, red_v;
    logic [TW-1:0] red_t;

    ptrf_storage #(.NREG(NREG), .DW(DW)) u_store (
        .clk(clk), .rst(rst),
        .we(we), .widx(dst), .wdata(wdata), .wtag(wtag),
        .ra(src_a), .rb(src_b),
        .ra_data(a_data), .ra_tag(a_tag),
        .rb_data(b_data), .rb_tag(b_tag)
    );

    ptrf_alu #(.DW(DW)) u_alu (
        .fn(alu_fn), .a(a_data), .b(b_data), .y(alu_y)
    );

    ptrf_ctrl #(.DW(DW), .TW(TW), .AW(AW)) u_ctrl (
        .op_valid(op_valid), .op_code(op_code), .dst(dst),
        .tag_a(a_tag), .tag_b(b_tag), .alu_y(alu_y),
        .ld_data(ld_data), .ld_fault(ld_fault), .defer_en(defer_en),
        .chk_target(chk_target),
        .we(we), .wdata(wdata), .wtag(wtag),
        .trap_v(trap_v), .trap_k(trap_k),
        .red_v(red_v), .red_t(red_t)
    );

    always_comb begin
        out_d        = '0;
        out_d.wb_v   = we;
        out_d.wb_i   = we ? dst : '0;
        out_d.wb_d   = we ? wdata : '0;
        out_d.wb_t   = we & wtag;
        out_d.trap_v = trap_v;
        out_d.trap_k = trap_v & trap_k;
        out_d.red_v  = red_v;
        out_d.red_t  = red_t;
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign wb_valid     = out_q.wb_v;
    assign wb_idx       = out_q.wb_i;
    assign wb_data      = out_q.wb_d;
    assign wb_tag       = out_q.wb_t;
    assign trap_valid   = out_q.trap_v;
    assign trap_kind    = out_q.trap_k;
    assign redir_valid  = out_q.red_v;
    assign redir_target = out_q.red_t;
endmodule

// File: rtl/ptrf_checker.sv
module ptrf_checker #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          op_valid,
    input logic [2:0]    op_code,
    input logic          wb_valid,
    input logic [AW-1:0] wb_idx,
    input logic          wb_tag,
    input logic          trap_valid,
    input logic          redir_valid
);
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wb_valid, trap_valid, redir_valid})); // R5
    AST_ZERO_NO_WB: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> wb_idx != '0); // R9
    AST_REDIR_FROM_CHECK: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> $past(op_valid && op_code == 3'd4)); // R7
    AST_TEST_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
        $past(op_valid && op_code == 3'd5) |-> !trap_valid); // R8
    AST_PLAIN_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && $past(op_valid && op_code == 3'd3)) |-> !wb_tag); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(!op_valid || op_code == 3'd0 || op_code > 3'd5)
            |-> !(wb_valid || trap_valid || redir_valid)); // R11
endmodule

bind ptrf_top ptrf_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_tag(wb_tag),
    .trap_valid(trap_valid), .redir_valid(redir_valid)
);

// File: tb/ptrf_top_tb.sv
module ptrf_top_tb_top;
    localparam int NREG = 16;
    localparam int DW   = 32;
    localparam int TW   = 32;
    localparam int AW   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic op_valid = 1'b0;
    logic [2:0] op_code = '0;
    logic [1:0] alu_fn = '0;
    logic [AW-1:0] src_a = '0, src_b = '0, dst = '0;
    logic [DW-1:0] ld_data = '0;
    logic ld_fault = 1'b0, defer_en = 1'b0;
    logic [TW-1:0] chk_target = '0;
    logic wb_valid, wb_tag, trap_valid, trap_kind, redir_valid;
    logic [AW-1:0] wb_idx;
    logic [DW-1:0] wb_data;
    logic [TW-1:0] redir_target;

    always #10 clk = ~clk;

    ptrf_top #(.NREG(NREG), .DW(DW), .TW(TW)) dut_i (.*);

    typedef struct {
        logic          wv;
        logic [AW-1:0] wi;
        logic [DW-1:0] wd;
        logic          wt;
        logic          tv;
        logic          tk;
        logic          rv;
        logic [TW-1:0] rt;
        string         req;
    } exp_s;

    exp_s q[$];
    int checks = 0, fails = 0;
    logic [DW-1:0] m_data [NREG];
    logic          m_tag  [NREG];
    bit done = 0;

    function automatic logic [DW-1:0] alu_ref(input logic [1:0] f, input logic [DW-1:0] a, input logic [DW-1:0] b);
        case (f)
            2'd0: return a + b;
            2'd1: return a - b;
            2'd2: return a & b;
            default: return a ^ b;
        endcase
    endfunction

    task automatic cmp(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input string req, input logic v, input logic [2:0] oc, input logic [1:0] fn,
                         input int a, input int b, input int d, input logic [DW-1:0] ld,
                         input logic flt, input logic dfr, input logic [TW-1:0] tgt);
        exp_s e;
        logic [DW-1:0] wd;
        logic wt, wr;
        @(negedge clk);
        op_valid = v; op_code = oc; alu_fn = fn;
        src_a = AW'(a); src_b = AW'(b); dst = AW'(d);
        ld_data = ld; ld_fault = flt; defer_en = dfr; chk_target = tgt;
        e = '{wv:0, wi:0, wd:0, wt:0, tv:0, tk:0, rv:0, rt:0, req:req};
        wr = 0; wd = '0; wt = 0;
        if (v) begin
            case (oc)
                3'd1: if (flt && !dfr) begin e.tv = 1; e.tk = 1; end
                      else begin wr = 1; wd = ld; wt = flt; end
                3'd2: begin wr = 1; wd = alu_ref(fn, m_data[a], m_data[b]); wt = m_tag[a] | m_tag[b]; end
                3'd3: if (m_tag[a] || m_tag[b]) begin e.tv = 1; e.tk = 0; end
                      else begin wr = 1; wd = alu_ref(fn, m_data[a], m_data[b]); end
                3'd4: if (m_tag[a]) begin e.rv = 1; e.rt = tgt; end
                3'd5: begin wr = 1; wd = DW'(m_tag[a]); end
                default: ;
            endcase
        end
        if (wr && d != 0) begin
            e.wv = 1; e.wi = AW'(d); e.wd = wd; e.wt = wt;
            m_data[d] = wd; m_tag[d] = wt;
        end
        q.push_back(e);
    endtask

    // monitor: pop one expected item per clock, sample away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_s e;
                e = q.pop_front();
                cmp(e.req, "wb_valid", 64'(wb_valid), 64'(e.wv));
                if (e.wv) begin
                    cmp(e.req, "wb_idx", 64'(wb_idx), 64'(e.wi));
                    cmp(e.req, "wb_data", 64'(wb_data), 64'(e.wd));
                    cmp(e.req, "wb_tag", 64'(wb_tag), 64'(e.wt));
                end
                cmp(e.req, "trap_valid", 64'(trap_valid), 64'(e.tv));
                if (e.tv) cmp(e.req, "trap_kind", 64'(trap_kind), 64'(e.tk));
                cmp(e.req, "redir_valid", 64'(redir_valid), 64'(e.rv));
                if (e.rv) cmp(e.req, "redir_target", 64'(redir_target), 64'(e.rt));
            end
        end
    end

    initial begin
        #4_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREG; i++) begin m_data[i] = '0; m_tag[i] = 1'b0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: outputs low straight out of reset
        cmp("R1", "outputs after reset", 64'({wb_valid, trap_valid, redir_valid}), 64'd0);
        issue("R1", 1, 3'd5, 0, 7, 0, 1, 0, 0, 0, 0);       // test r7 poison -> 0
        issue("R1", 1, 3'd2, 0, 9, 12, 2, 0, 0, 0, 0);      // r9+r12 = 0, clean
        issue("R2", 1, 3'd1, 0, 0, 0, 1, 32'h1234, 0, 0, 0);
        issue("R3", 1, 3'd1, 0, 0, 0, 2, 32'h0bad, 1, 1, 0); // deferred -> poison
        issue("R3", 1, 3'd1, 0, 0, 0, 3, 32'h7777, 1, 0, 0); // not deferred -> trap
        issue("R3", 1, 3'd2, 0, 3, 0, 11, 0, 0, 0, 0);      // r3 untouched (0)
        issue("R4", 1, 3'd2, 0, 1, 2, 4, 0, 0, 0, 0);       // poison spreads
        issue("R4", 1, 3'd2, 0, 4, 1, 12, 0, 0, 0, 0);      // second hop
        issue("R10", 1, 3'd2, 3, 1, 1, 5, 0, 0, 0, 0);      // xor
        issue("R10", 1, 3'd1, 0, 0, 0, 13, 32'h00f0, 0, 0, 0);
        issue("R10", 1, 3'd2, 1, 1, 13, 14, 0, 0, 0, 0);    // sub
        issue("R10", 1, 3'd2, 2, 1, 13, 15, 0, 0, 0, 0);    // and
        issue("R5", 1, 3'd3, 0, 4, 1, 6, 0, 0, 0, 0);       // plain on poison a
        issue("R5", 1, 3'd3, 0, 1, 2, 1, 0, 0, 0, 0);       // plain on poison b, r1 kept
        issue("R5", 1, 3'd2, 0, 1, 6, 7, 0, 0, 0, 0);       // r1 and r6 unchanged
        issue("R6", 1, 3'd3, 1, 1, 3, 4, 0, 0, 0, 0);       // clean overwrite of poisoned r4
        issue("R6", 1, 3'd5, 0, 4, 0, 8, 0, 0, 0, 0);       // r4 now clean
        issue("R7", 1, 3'd4, 0, 2, 0, 0, 0, 0, 0, 32'hABCD);
        issue("R7", 1, 3'd4, 0, 1, 0, 0, 0, 0, 0, 32'h5555);
        issue("R8", 1, 3'd5, 0, 2, 0, 9, 0, 0, 0, 0);
        issue("R8", 1, 3'd5, 0, 12, 0, 10, 0, 0, 0, 0);
        issue("R9", 1, 3'd1, 0, 0, 0, 0, 32'hdead, 1, 1, 0);
        issue("R9", 1, 3'd2, 0, 0, 0, 10, 0, 0, 0, 0);      // r0 still zero, clean
        issue("R11", 1, 3'd6, 0, 1, 1, 5, 32'h1, 1, 0, 0);
        issue("R11", 1, 3'd7, 0, 2, 2, 5, 32'h2, 0, 0, 0);
        issue("R11", 0, 3'd1, 0, 0, 0, 5, 32'h3, 1, 0, 0);
        issue("R11", 1, 3'd0, 0, 0, 0, 5, 32'h4, 0, 0, 0);
        issue("R11", 1, 3'd2, 0, 5, 0, 11, 0, 0, 0, 0);     // r5 unchanged
        issue("R11", 0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule